// File: doc/BRIEF.md
# Dual-Clock Single-Bit Elastic FIFO

This block buffers a serial bit stream between two clock domains that may be unrelated in frequency and phase, or may share one clock. A producer pushes one bit per write-clock edge while the block signals room. A consumer finds the oldest bit already waiting on the output, marked by a ready flag, and removes it with a read enable. No request is needed to see the head bit.

The storage array keeps `DEPTH` bits (64 or 256). Its pointers cross between the domains in Gray code. The pointer arriving in the write domain passes through two flops. The pointer arriving in the read domain passes through three. The head bit is moved out of the array into an output register, so it no longer counts as stored. Two status flags are computed in the write domain from the stored count: a half-full flag, and a single near-limit flag that warns of both the near-empty and the near-full condition. An output-enable input models a three-state data pin through a separate drive-enable output.

Top module: `serial_elastic_fifo`

## Requirements
- R1: A bit is written on a rising `wr_clk` edge only when `wr_en` and `in_ready` are both high. `in_ready` goes low once `DEPTH` bits are stored in the array. When the output stage is also counted, exactly `DEPTH`+1 bits are accepted before writes stall, and holding `wr_en` high while `in_ready` is low adds nothing.
- R2: The head bit is removed on a rising `rd_clk` edge only when `rd_en` and `out_ready` are both high. Raising `rd_en` while `out_ready` is low has no effect. Reading the last bit drops `out_ready`.
- R3: After a bit is written, `out_ready` rises and the bit appears on `rd_bit` with no read request. Bits leave in the order they were written.
- R4: `half_full` is high exactly when the stored count is at least `DEPTH`/2. The stored count excludes the bit held in the output register.
- R5: `near_limit` is high exactly when the stored count is 8 or less, or when 8 or fewer free places remain. Here too the stored count excludes the output-register bit.
- R6: With `out_en` low, `rd_bit_drive` is 0 and `rd_bit` reads 0. With `out_en` high, `rd_bit_drive` is 1 and `rd_bit` shows the head bit. `out_en` never changes `out_ready`.
- R7: After reset, `in_ready`=1, `out_ready`=0, `half_full`=0 and `near_limit`=1. Reset is asynchronous and is released separately in each domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write-domain clock |
| wr_en | input | 1 | Write request |
| wr_bit | input | 1 | Serial data in |
| in_ready | output | 1 | Room for another bit (write domain) |
| half_full | output | 1 | Stored count at least half the depth (write domain) |
| near_limit | output | 1 | Stored count or free space at most 8 (write domain) |
| rd_clk | input | 1 | Read-domain clock |
| rd_en | input | 1 | Read request |
| out_en | input | 1 | Output drive enable |
| rd_bit | output | 1 | Head bit, forced 0 when not driven |
| rd_bit_drive | output | 1 | High when the data output would be driven |
| out_ready | output | 1 | Head bit valid (read domain) |

## Verification
The assertions assume that `wr_en` and `rd_en` change only away from their own clock's rising edge. They also assume that reset is held long enough to be seen in both domains. The bench drives every input on the falling edge of the clock it belongs to and holds reset for many cycles of the slower clock. The clocks run at unrelated periods, so pointer crossings happen at varied phases. Flag values are checked only after a settling wait long enough for both synchronizer chains to catch up.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  function automatic logic [15:0] bin2gray(input logic [15:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [15:0] gray2bin(input logic [15:0] g);
    logic [15:0] b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic half_level(input int unsigned cnt, input int unsigned depth);
    return cnt >= depth / 2;
  endfunction

  function automatic logic edge_level(input int unsigned cnt, input int unsigned depth,
                                      input int unsigned margin);
    return (cnt <= margin) || ((depth - cnt) <= margin);
  endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sfifo_wr_port.sv
module sfifo_wr_port
  import sfifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int MARGIN = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_bit,
  input  logic [PW-1:0] rgray_sync,
  input  logic [AW-1:0] rd_addr,
  output logic          mem_bit,
  output logic [PW-1:0] wgray,
  output logic [PW-1:0] wptr_bin,
  output logic [PW-1:0] wcount,
  output logic          in_ready,
  output logic          half_full,
  output logic          near_limit
);
  logic          mem [DEPTH];
  logic [PW-1:0] rbin;
  logic [PW-1:0] wnext;
  logic          wr_fire;

  assign rbin       = PW'(gray2bin(16'(rgray_sync)));
  assign wcount     = wptr_bin - rbin;
  assign in_ready   = (wcount != PW'(DEPTH));
  assign wr_fire    = wr_en && in_ready;
  assign wnext      = wptr_bin + PW'(1);
  assign half_full  = half_level(32'(wcount), DEPTH);
  assign near_limit = edge_level(32'(wcount), DEPTH, MARGIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_bin <= '0;
      wgray    <= '0;
    end else if (wr_fire) begin
      wptr_bin <= wnext;
      wgray    <= PW'(bin2gray(16'(wnext)));
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr_bin[AW-1:0]] <= wr_bit;
  end

  assign mem_bit = mem[rd_addr];
endmodule

// File: rtl/sfifo_rd_port.sv
module sfifo_rd_port
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [PW-1:0] wgray_sync,
  input  logic          mem_bit,
  output logic [AW-1:0] rd_addr,
  output logic [PW-1:0] rgray,
  output logic          head_bit,
  output logic          out_ready,
  output logic          rd_fire,
  output logic          mem_empty
);
  logic [PW-1:0] rptr;
  logic [PW-1:0] wbin;
  logic [PW-1:0] rnext;
  logic          load;

  assign wbin      = PW'(gray2bin(16'(wgray_sync)));
  assign mem_empty = (rptr == wbin);
  assign rd_fire   = rd_en && out_ready;
  assign load      = !mem_empty && (!out_ready || rd_fire);
  assign rnext     = rptr + PW'(1);
  assign rd_addr   = rptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr      <= '0;
      rgray     <= '0;
      head_bit  <= 1'b0;
      out_ready <= 1'b0;
    end else if (load) begin
      rptr      <= rnext;
      rgray     <= PW'(bin2gray(16'(rnext)));
      head_bit  <= mem_bit;
      out_ready <= 1'b1;
    end else if (rd_fire) begin
      out_ready <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_elastic_fifo.sv
module serial_elastic_fifo #(
  parameter int DEPTH     = 64,
  parameter int MARGIN    = 8,
  parameter int IR_STAGES = 2,
  parameter int OR_STAGES = 3
) (
  input  logic rst_n,
  input  logic wr_clk,
  input  logic wr_en,
  input  logic wr_bit,
  output logic in_ready,
  output logic half_full,
  output logic near_limit,
  input  logic rd_clk,
  input  logic rd_en,
  input  logic out_en,
  output logic rd_bit,
  output logic rd_bit_drive,
  output logic out_ready
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          wr_rst_n_s, rd_rst_n_s;
  logic [PW-1:0] wgray, rgray, wgray_rd, rgray_wr;
  logic [PW-1:0] wptr_bin, wcount;
  logic [AW-1:0] rd_addr;
  logic          mem_bit, head_bit, rd_fire, mem_empty;

  sync_chain #(.W(1), .STAGES(2)) wr_rst_i (
    .clk(wr_clk), .rst_n(rst_n), .d(1'b1), .q(wr_rst_n_s));
  sync_chain #(.W(1), .STAGES(2)) rd_rst_i (
    .clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(rd_rst_n_s));

  sync_chain #(.W(PW), .STAGES(IR_STAGES)) r2w_i (
    .clk(wr_clk), .rst_n(wr_rst_n_s), .d(rgray), .q(rgray_wr));
  sync_chain #(.W(PW), .STAGES(OR_STAGES)) w2r_i (
    .clk(rd_clk), .rst_n(rd_rst_n_s), .d(wgray), .q(wgray_rd));

  sfifo_wr_port #(.DEPTH(DEPTH), .MARGIN(MARGIN)) wr_i (
    .clk(wr_clk), .rst_n(wr_rst_n_s), .wr_en(wr_en), .wr_bit(wr_bit),
    .rgray_sync(rgray_wr), .rd_addr(rd_addr), .mem_bit(mem_bit),
    .wgray(wgray), .wptr_bin(wptr_bin), .wcount(wcount),
    .in_ready(in_ready), .half_full(half_full), .near_limit(near_limit));

  sfifo_rd_port #(.DEPTH(DEPTH)) rd_i (
    .clk(rd_clk), .rst_n(rd_rst_n_s), .rd_en(rd_en), .wgray_sync(wgray_rd),
    .mem_bit(mem_bit), .rd_addr(rd_addr), .rgray(rgray), .head_bit(head_bit),
    .out_ready(out_ready), .rd_fire(rd_fire), .mem_empty(mem_empty));

  assign rd_bit_drive = out_en;
  assign rd_bit       = out_en & head_bit;
endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
  parameter int DEPTH = 64,
  parameter int PW    = 7
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wr_rst_n_s,
  input logic          rd_rst_n_s,
  input logic          wr_en,
  input logic          in_ready,
  input logic          half_full,
  input logic          near_limit,
  input logic [PW-1:0] wptr_bin,
  input logic [PW-1:0] wcount,
  input logic          rd_en,
  input logic          out_ready,
  input logic          head_bit,
  input logic          mem_empty,
  input logic          rd_fire
);
  // R1
  blocked_write_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n_s)
    (wr_en && !in_ready) |=> $stable(wptr_bin));

  // R1
  count_bound_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n_s)
    wcount <= PW'(DEPTH));

  // R4
  full_flags_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n_s)
    !in_ready |-> (half_full && near_limit));

  // R2
  held_head_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n_s)
    (out_ready && !rd_en) |=> (out_ready && $stable(head_bit)));

  // R2
  last_read_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n_s)
    (rd_fire && mem_empty) |=> !out_ready);
endmodule

bind serial_elastic_fifo sfifo_chk #(.DEPTH(DEPTH), .PW(PW)) chk_i (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n_s(wr_rst_n_s), .rd_rst_n_s(rd_rst_n_s),
  .wr_en(wr_en), .in_ready(in_ready), .half_full(half_full), .near_limit(near_limit),
  .wptr_bin(wptr_bin), .wcount(wcount), .rd_en(rd_en), .out_ready(out_ready),
  .head_bit(head_bit), .mem_empty(mem_empty), .rd_fire(rd_fire));

// File: tb/serial_elastic_fifo_tb_top.sv
module serial_elastic_fifo_tb_top;
  localparam int DEPTH = 64;

  logic rst_n = 1'b0, wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_en = 1'b0, wr_bit = 1'b0, rd_en = 1'b0, out_en = 1'b1;
  logic in_ready, half_full, near_limit, rd_bit, rd_bit_drive, out_ready;
  int   checks = 0, errors = 0;
  int   widx = 0;

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  serial_elastic_fifo #(.DEPTH(DEPTH)) dut_i (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_bit(wr_bit),
    .in_ready(in_ready), .half_full(half_full), .near_limit(near_limit),
    .rd_clk(rd_clk), .rd_en(rd_en), .out_en(out_en), .rd_bit(rd_bit),
    .rd_bit_drive(rd_bit_drive), .out_ready(out_ready));

  function automatic logic pat(input int i);
    logic [15:0] v;
    v = 16'(i * 37 + (i >> 2));
    return ^v;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_en = 0; rd_en = 0; out_en = 1; widx = 0;
    rst_n = 0;
    repeat (6) @(negedge rd_clk);
    rst_n = 1;
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic settle();
    repeat (30) @(negedge wr_clk);
  endtask

  task automatic write_n(input int n);
    int done = 0;
    while (done < n) begin
      @(negedge wr_clk);
      if (in_ready) begin
        wr_en = 1; wr_bit = pat(widx); widx++; done++;
      end else wr_en = 0;
    end
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge wr_clk);
    check(in_ready == 1, "R7 in_ready", in_ready, 1);
    check(half_full == 0, "R7 half_full", half_full, 0);
    check(near_limit == 1, "R7 near_limit", near_limit, 1);
    @(negedge rd_clk);
    check(out_ready == 0, "R7 out_ready", out_ready, 0);
  endtask

  task automatic t_fall_through();
    do_reset();
    write_n(1);
    settle();
    @(negedge rd_clk);
    check(out_ready == 1, "R3 out_ready without read", out_ready, 1);
    check(rd_bit == pat(0), "R3 head bit", rd_bit, pat(0));
    @(negedge wr_clk);
    check(near_limit == 1 && half_full == 0, "R5 empty array", {half_full, near_limit}, 1);
  endtask

  task automatic t_out_enable();
    do_reset();
    while (pat(widx) != 1'b1) widx++;
    write_n(1);
    settle();
    @(negedge rd_clk);
    out_en = 0;
    @(negedge rd_clk);
    check(rd_bit_drive == 0 && rd_bit == 0, "R6 disabled", {rd_bit_drive, rd_bit}, 0);
    check(out_ready == 1, "R6 ready kept", out_ready, 1);
    out_en = 1;
    @(negedge rd_clk);
    check(rd_bit_drive == 1 && rd_bit == 1, "R6 enabled", {rd_bit_drive, rd_bit}, 3);
  endtask

  task automatic t_idle_read();
    do_reset();
    @(negedge rd_clk);
    rd_en = 1;
    repeat (10) @(negedge rd_clk);
    rd_en = 0;
    write_n(1);
    settle();
    @(negedge rd_clk);
    check(out_ready == 1 && rd_bit == pat(0), "R2 idle read ignored", {out_ready, rd_bit}, {1'b1, pat(0)});
    rd_en = 1;
    @(negedge rd_clk);
    rd_en = 0;
    check(out_ready == 0, "R2 last read drops ready", out_ready, 0);
    settle();
    @(negedge rd_clk);
    check(out_ready == 0, "R2 stays empty", out_ready, 0);
  endtask

  task automatic t_thresholds();
    do_reset();
    write_n(9); settle();
    check(near_limit == 1, "R5 eight stored", near_limit, 1);
    write_n(1); settle();
    check(near_limit == 0, "R5 nine stored", near_limit, 0);
    write_n(DEPTH/2 - 10); settle();
    check(half_full == 0, "R4 half minus one", half_full, 0);
    write_n(1); settle();
    check(half_full == 1, "R4 exactly half", half_full, 1);
    write_n(DEPTH - 8 - DEPTH/2 - 1); settle();
    check(near_limit == 0, "R5 nine free", near_limit, 0);
    write_n(1); settle();
    check(near_limit == 1, "R5 eight free", near_limit, 1);
  endtask

  task automatic t_fill_drain();
    int accepted = 0, idle = 0, got = 0, bad = 0;
    do_reset();
    while (idle < 40) begin
      @(negedge wr_clk);
      if (in_ready) begin
        wr_en = 1; wr_bit = pat(accepted); accepted++; idle = 0;
      end else begin
        wr_en = 1; wr_bit = 1'b1; idle++;
      end
    end
    @(negedge wr_clk);
    check(in_ready == 0, "R1 full flag", in_ready, 0);
    check(half_full == 1 && near_limit == 1, "R4 full flags", {half_full, near_limit}, 3);
    wr_en = 0;
    check(accepted == DEPTH + 1, "R1 capacity", accepted, DEPTH + 1);
    idle = 0;
    while (idle < 40) begin
      @(negedge rd_clk);
      if (out_ready) begin
        if (rd_bit != pat(got)) bad++;
        got++; rd_en = 1; idle = 0;
      end else begin
        rd_en = 0; idle++;
      end
    end
    check(got == DEPTH + 1, "R1 drained count", got, DEPTH + 1);
    check(bad == 0, "R3 order", bad, 0);
    @(negedge wr_clk);
    check(in_ready == 1, "R1 room again", in_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_fall_through();
    t_out_enable();
    t_idle_read();
    t_thresholds();
    t_fill_drain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule